// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block gives software control of 32 general-purpose pins through six word-wide registers on a simple bus. The bus has read and write strobes, an address and a transfer size. Each pin can be set as an input or an output. Output pins drive the value software writes to the data register. Input pins pass through a two-flop synchroniser, and their level is copied into the data register when it changes.

Each input pin can record an event on any transition or on a falling transition only, as chosen by its control bit. Events stay pending until software clears them by writing ones. A single level interrupt is high while any pending event has its mask bit set.

Register bit 31 belongs to pin 0 and bit 0 belongs to pin 31. The open-drain select is only stored and brought out as a per-pin vector for the pad ring. The pad ring also takes the per-pin output enable and the driven values.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all six registers read zero. `pin_out`, `pin_dir`, `pin_od` and `irq` are all zero.
- R2: A full-word write at offsets 0x00 (direction), 0x04 (open-drain), 0x10 (mask) or 0x14 (control) is read back unchanged. Pin i of `pin_dir` and `pin_od` shows register bit 31-i.
- R3: Only `bus_size` = 2'b10 (word) is a full access. A write with 2'b00 (byte) or 2'b01 (half) changes no register. A read with either of those sizes returns zero.
- R4: A read at an offset other than the six mapped ones (0x00, 0x04, 0x08, 0x0C, 0x10, 0x14) returns zero. A write to such an offset changes no register.
- R5: A full write to the data register (0x08) sets `pin_out[i]` to bit 31-i of the written word for every pin whose direction bit is 1. `pin_out` of input pins keeps its previous value.
- R6: On an input pin (direction bit 0), a level change on `pin_in` reaches the data register on the third rising clock edge after the change. A level change on an output pin leaves its data bit unchanged.
- R7: When an input pin's control bit is 0, a rising or a falling transition sets its event bit (register 0x0C, bit 31-i).
- R8: When an input pin's control bit is 1, only a high-to-low transition sets its event bit. A low-to-high transition leaves it clear.
- R9: A full write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: `irq` is high exactly when the AND of the event and mask registers is nonzero. It follows a register write from the next clock.
- R11: When an edge sets an event bit in the same cycle that software clears it, the bit ends up set.
- R12: Transitions on output-direction pins never set event bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_wr | input | 1 | Write strobe; takes effect on the rising edge |
| bus_addr | input | 12 | Byte offset of the register |
| bus_size | input | 2 | Transfer size: 00 byte, 01 half, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not a full read of a mapped offset |
| pin_in | input | 32 | Pin levels from the pads, index = pin number |
| pin_out | output | 32 | Driven values for output pins, index = pin number |
| pin_dir | output | 32 | Output enable per pin, index = pin number |
| pin_od | output | 32 | Open-drain select per pin, index = pin number |
| irq | output | 1 | Level interrupt request |

## Verification
Wrong internal state in this block shows up at the ports in two ways: as a wrong readback word, or as a wrong level on `irq` or `pin_out`.

If the event register is corrupted, `irq` shows it on the next clock whenever the bit is masked in. A read of offset 0x0C shows it at any time. A fault in the synchroniser or the edge qualifier moves or drops the update that is expected on the third edge after a pin change. The bench therefore reads the data and event registers right after that edge. Any error in bit order or in the direction gating flips a named pin in `pin_out` or `pin_dir` one clock after the write that caused it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Register slots, used as indices into the one-hot write vector
  localparam int unsigned IDX_DIR = 0;
  localparam int unsigned IDX_OD  = 1;
  localparam int unsigned IDX_DAT = 2;
  localparam int unsigned IDX_EVT = 3;
  localparam int unsigned IDX_MSK = 4;
  localparam int unsigned IDX_CTL = 5;
  localparam int unsigned NREG    = 6;

  // Byte offsets of the registers
  localparam int unsigned OFF_DIR = 'h00;
  localparam int unsigned OFF_OD  = 'h04;
  localparam int unsigned OFF_DAT = 'h08;
  localparam int unsigned OFF_EVT = 'h0C;
  localparam int unsigned OFF_MSK = 'h10;
  localparam int unsigned OFF_CTL = 'h14;

  // Transfer size code for a full-word access
  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [DW-1:0]      r_dir,
  input  logic [DW-1:0]      r_od,
  input  logic [DW-1:0]      r_dat,
  input  logic [DW-1:0]      r_evt,
  input  logic [DW-1:0]      r_msk,
  input  logic [DW-1:0]      r_ctl,
  output logic [NREG-1:0]    reg_we,
  output logic [DW-1:0]      bus_rdata
);
  logic [NREG-1:0] sel_oh;
  logic            full;

  assign full = (bus_size == SIZE_WORD);

  always_comb begin
    sel_oh = '0;
    if      (bus_addr == AW'(OFF_DIR)) sel_oh[IDX_DIR] = 1'b1;
    else if (bus_addr == AW'(OFF_OD))  sel_oh[IDX_OD]  = 1'b1;
    else if (bus_addr == AW'(OFF_DAT)) sel_oh[IDX_DAT] = 1'b1;
    else if (bus_addr == AW'(OFF_EVT)) sel_oh[IDX_EVT] = 1'b1;
    else if (bus_addr == AW'(OFF_MSK)) sel_oh[IDX_MSK] = 1'b1;
    else if (bus_addr == AW'(OFF_CTL)) sel_oh[IDX_CTL] = 1'b1;
  end

  assign reg_we = (bus_wr && full) ? sel_oh : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && full) begin
      if (sel_oh[IDX_DIR]) bus_rdata = r_dir;
      if (sel_oh[IDX_OD])  bus_rdata = r_od;
      if (sel_oh[IDX_DAT]) bus_rdata = r_dat;
      if (sel_oh[IDX_EVT]) bus_rdata = r_evt;
      if (sel_oh[IDX_MSK]) bus_rdata = r_msk;
      if (sel_oh[IDX_CTL]) bus_rdata = r_ctl;
    end
  end

  // R4: unmapped reads return zero
  a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != AW'(OFF_DIR) && bus_addr != AW'(OFF_OD) &&
     bus_addr != AW'(OFF_DAT) && bus_addr != AW'(OFF_EVT) &&
     bus_addr != AW'(OFF_MSK) && bus_addr != AW'(OFF_CTL)) |-> (bus_rdata == '0));

  // R3: narrow reads return zero
  a_r3_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size != SIZE_WORD) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_d, s1_q, s2_q, prev_q;

  // Pin i lands on register bit N-1-i
  for (genvar i = 0; i < N; i++) begin : g_map
    assign s1_d[N-1-i] = pin_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  // R6: a detected edge traces back to the synchroniser one cycle earlier
  a_r6_edge_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((rise | fall) == ($past(s1_q) ^ $past(s2_q))));
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] ctl,
  input  logic [N-1:0] mask,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] ev_q,
  output logic         irq
);
  logic [N-1:0] set_v, clr_v, ev_d;

  always_comb begin
    set_v = ~dir & (fall | (rise & ~ctl));
    clr_v = clr_en ? clr_bits : '0;
    ev_d  = (ev_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign irq = |(ev_q & mask);

  // R11: a set bit is present on the next cycle regardless of any clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((ev_q & $past(set_v)) == $past(set_v)));

  // R9: a cleared bit with no coincident set drops
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((ev_q & $past(clr_bits) & ~$past(set_v)) == '0));

  // R12: output-direction pins never gain an event
  a_r12_out_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((ev_q & ~$past(ev_q) & $past(dir)) == '0));

  // R8: with control set, a new event needs a falling edge
  a_r8_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((ev_q & ~$past(ev_q) & $past(ctl) & ~$past(fall)) == '0));

  // R10: no interrupt without a masked-in pending event
  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && ev_q != '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_dir,
  output logic [DW-1:0] pin_od,
  output logic          irq
);
  localparam int unsigned N = DW;

  logic [NREG-1:0] reg_we;
  logic [N-1:0]    dir_q, od_q, msk_q, ctl_q, dat_q, drv_q, ev_q;
  logic [N-1:0]    dat_d, drv_d, upd;
  logic [N-1:0]    lvl, rise, fall;

  gpio_bus_dec #(.AW(AW), .DW(DW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .r_dir     (dir_q),
    .r_od      (od_q),
    .r_dat     (dat_q),
    .r_evt     (ev_q),
    .r_msk     (msk_q),
    .r_ctl     (ctl_q),
    .reg_we    (reg_we),
    .bus_rdata (bus_rdata)
  );

  gpio_insync #(.N(N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .lvl    (lvl),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_event #(.N(N)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .fall     (fall),
    .dir      (dir_q),
    .ctl      (ctl_q),
    .mask     (msk_q),
    .clr_en   (reg_we[IDX_EVT]),
    .clr_bits (bus_wdata),
    .ev_q     (ev_q),
    .irq      (irq)
  );

  // Configuration registers with explicit write enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      od_q  <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else begin
      if (reg_we[IDX_DIR]) dir_q <= bus_wdata;
      if (reg_we[IDX_OD])  od_q  <= bus_wdata;
      if (reg_we[IDX_MSK]) msk_q <= bus_wdata;
      if (reg_we[IDX_CTL]) ctl_q <= bus_wdata;
    end
  end

  // Data and drive next state: pin updates on input bits override software
  always_comb begin
    upd   = ~dir_q & (rise | fall);
    dat_d = reg_we[IDX_DAT] ? bus_wdata : dat_q;
    dat_d = (dat_d & ~upd) | (lvl & upd);
    drv_d = reg_we[IDX_DAT] ? ((drv_q & ~dir_q) | (bus_wdata & dir_q)) : drv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      drv_q <= '0;
    end else begin
      dat_q <= dat_d;
      drv_q <= drv_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pins
    assign pin_out[i] = drv_q[N-1-i];
    assign pin_dir[i] = dir_q[N-1-i];
    assign pin_od[i]  = od_q[N-1-i];
  end

  // R3: a narrow write leaves every stored register alone
  a_r3_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != SIZE_WORD) |=>
      ($stable(dir_q) && $stable(od_q) && $stable(msk_q) && $stable(ctl_q) && $stable(drv_q)));

  // R5: driven values move only after a data write
  a_r5_drive_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we[IDX_DAT] |=> $stable(pin_out));

  // R6: output-direction data bits move only by software
  a_r6_out_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we[IDX_DAT] |=> (((dat_q ^ $past(dat_q)) & $past(dir_q)) == '0));
endmodule

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  logic        clk, rst_n;
  logic        bus_rd, bus_wr;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_dir, pin_od;
  logic        irq;

  int checks = 0;
  int errors = 0;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_dir(pin_dir), .pin_od(pin_od), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{12'h000, 2'b10, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    '{12'h004, 2'b10, 32'h1234_5678, 32'h1234_5678},
    '{12'h010, 2'b10, 32'hFFFF_0000, 32'hFFFF_0000},
    '{12'h014, 2'b10, 32'h0000_FFFF, 32'h0000_FFFF},
    '{12'h000, 2'b00, 32'hFFFF_FFFF, 32'hA5A5_0F0F},
    '{12'h004, 2'b01, 32'h0000_0000, 32'h1234_5678},
    '{12'h018, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000},
    '{12'h040, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000},
    '{12'h002, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000},
    '{12'h000, 2'b10, 32'h0000_0000, 32'h0000_0000},
    '{12'h004, 2'b10, 32'h0000_0000, 32'h0000_0000},
    '{12'h010, 2'b10, 32'h0000_0000, 32'h0000_0000},
    '{12'h014, 2'b10, 32'h0000_0000, 32'h0000_0000}
  };

  function automatic logic [31:0] rev(input logic [31:0] x);
    for (int i = 0; i < 32; i++) rev[i] = x[31-i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_size = 2'b10; bus_wdata = 0; pin_in = 0;
    do_reset();

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(12'(a*4), 2'b10, r);
      check("R1 reg after reset", r, 32'h0);
    end
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_dir", pin_dir, 0);
    check("R1 pin_od", pin_od, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 R3 R4: table walk
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k].addr, VEC[k].size, VEC[k].wdata);
      rd(VEC[k].addr, 2'b10, r);
      check($sformatf("R2/R3/R4 vector %0d", k), r, VEC[k].exp);
    end

    // R2: pin export order
    wr(12'h000, 2'b10, 32'hF000_0000);
    check("R2 pin_dir order", pin_dir, 32'h0000_000F);
    wr(12'h004, 2'b10, 32'hC000_0000);
    check("R2 pin_od order", pin_od, 32'h0000_0003);
    rd(12'h000, 2'b00, r);
    check("R3 narrow read zero", r, 0);

    // R5: drive only output pins
    wr(12'h008, 2'b10, 32'hA000_00FF);
    check("R5 pin_out", pin_out, 32'h0000_0005);
    wr(12'h008, 2'b10, 32'hA000_0000);
    check("R5 pin_out input bits held", pin_out, 32'h0000_0005);

    // R6 R7 R12: pin 31 input rises, pin 1 output toggles
    pins(32'h8000_0002);
    rd(12'h008, 2'b10, r);
    check("R6 data follows input only", r, 32'hA000_0001);
    rd(12'h00C, 2'b10, r);
    check("R12 R7 events", r, 32'h0000_0001);
    check("R10 irq masked", {31'b0, irq}, 0);

    // R10 R9
    wr(12'h010, 2'b10, 32'h0000_0001);
    check("R10 irq on mask", {31'b0, irq}, 1);
    wr(12'h00C, 2'b10, 32'h0000_0000);
    rd(12'h00C, 2'b10, r);
    check("R9 zero write keeps", r, 32'h1);
    wr(12'h00C, 2'b01, 32'hFFFF_FFFF);
    rd(12'h00C, 2'b10, r);
    check("R3 narrow event write ignored", r, 32'h1);
    wr(12'h00C, 2'b10, 32'h0000_0001);
    rd(12'h00C, 2'b10, r);
    check("R9 one write clears", r, 32'h0);
    check("R10 irq drops", {31'b0, irq}, 0);

    // R8: pins 30 and 31 falling only
    wr(12'h014, 2'b10, 32'h0000_0003);
    pins(32'h4000_0002);
    rd(12'h00C, 2'b10, r);
    check("R8 rise ignored, fall sets", r, 32'h1);
    check("R10 irq high", {31'b0, irq}, 1);
    pins(32'h0000_0002);
    rd(12'h00C, 2'b10, r);
    check("R8 fall on pin 30", r, 32'h3);

    // R7: pin 29 rise with control 0
    pins(32'h2000_0002);
    rd(12'h00C, 2'b10, r);
    check("R7 any edge rise", r, 32'h7);

    // R11: fall on pin 29 coincides with clear of bit 2
    @(negedge clk);
    pin_in = 32'h0000_0002;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h00C; bus_size = 2'b10; bus_wdata = 32'h4;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(12'h00C, 2'b10, r);
    check("R11 set wins over clear", r, 32'h7);
    wr(12'h00C, 2'b10, 32'h4);
    rd(12'h00C, 2'b10, r);
    check("R9 later clear", r, 32'h3);
    rd(12'h008, 2'b10, r);
    check("R6 data after falls", r, 32'hA000_0000);

    // R1: reset mid-run
    @(negedge clk);
    pin_in = 0;
    repeat (4) @(posedge clk);
    do_reset();
    rd(12'h00C, 2'b10, r);
    check("R1 event after reset", r, 0);
    rd(12'h000, 2'b10, r);
    check("R1 dir after reset", r, 0);
    check("R1 pin_out after reset", pin_out, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);

    if (rev(32'h1) != 32'h8000_0000) begin
      checks++; errors++;
      $display("FAIL bench mapping helper");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule